// File: doc/BRIEF.md
# Branch-Steered Functional Unit Array

This block is a small coarse-grained compute array for a processor's accelerator slot. A hot region of straight-line code, which may hold several branches, is mapped onto a grid of functional units arranged in rows. Each unit performs one ALU operation or one compare per evaluation. Operands come through multiplexers that select either one of the array's primary inputs or the result of a unit in an earlier row. An operand can be made conditional. In that case a one-bit selector forwards the outcome of a chosen compare unit, and that outcome decides between two configured candidate sources. One configuration can therefore follow whichever path the branches take at run time.

The whole evaluation is combinational from the primary inputs. A one-cycle start pulse captures every output port, together with a per-port valid bit, into registers and raises done on the following cycle. Each output port names the unit it reports. It is either unconditional or guarded by one compare unit's outcome and a polarity, so the host can tell which of the candidate results belong to the path that was actually taken. The routing and the opcodes are loaded one entry per cycle through an address/data/write-enable port. This configuration is expected to stay steady while start is in use.

Top module: `cxa_array`

## Requirements
- R1: Synchronous active-low reset clears out_data, out_valid and done. It also clears every configuration entry to zero, so each unit passes primary input 0 and each output port reports unit 0 unconditionally.
- R2: Unit opcodes, in the 4-bit field: 0 pass A, 1 add, 2 sub (A-B), 3 and, 4 or, 5 xor, 6 shift A left, 7 shift A right logically, 8 shift A right arithmetically. Codes 12 to 15 produce data 0 and no flag.
- R3: Compare opcodes 9 (A==B), 10 (A!=B) and 11 (A signed >= 0) set the unit's one-bit flag and drive its data result to 0. Every non-compare unit has its flag at 0.
- R4: Source codes 0 to NIN-1 select a primary input. Code NIN+k selects unit k, where k = row*COLS+column. A code that names a unit in the same row or a later row, or that lies beyond the last unit, reads 0.
- R5: An operand field is {cond unit[3], cond enable[1], taken source[4], not-taken source[4]}, with the MSB on the left. With the enable set, the named unit's flag picks the taken source when it is 1 and the not-taken source when it is 0. With the enable clear, the not-taken source is always used.
- R6: A selector that names a unit which is not a compare, lies in the same row or a later row, or lies past the last unit reads 0, so the not-taken source is chosen.
- R7: An output port entry is {polarity[1], cond unit[3], cond enable[1], data unit[3]}, with the MSB on the left. The port reports that unit's data, or 0 if the index is past the last unit. With the enable clear the valid bit is 1. Otherwise the valid bit is 1 only when the named unit's flag equals the polarity; a unit that does not exist counts as flag 0.
- R8: A start pulse samples all ports into out_data and out_valid at that clock edge, and done is high exactly in the cycle after each start. Without start the registered outputs hold even when the inputs change.
- R9: A configuration write goes to unit u at address u (word = {operand B[12], operand A[12], opcode[4]}) and to output port p at address NU+p. Writes to higher addresses change nothing.
- R10: Shift amounts use only the low log2(W) bits of operand B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration entry address |
| cfg_wdata | input | 28 | Configuration entry contents |
| in_data | input | 128 | Primary inputs, input i in bits [32i+31:32i] |
| start | input | 1 | Capture outputs this cycle |
| done | output | 1 | High in the cycle after start |
| out_data | output | 96 | Registered port results, port p in bits [32p+31:32p] |
| out_valid | output | 3 | Registered per-port valid bits |

## Verification
The bench uses the defaults: three rows of two 32-bit units, four primary inputs and three output ports. With three rows, a unit in the last row can see units in both earlier rows, while same-row and forward references stay illegal. A three-bit unit index reaches the two codes past the last unit, so out-of-range selectors and data indices can be exercised. With a 32-bit datapath, a shift operand carrying bit 5 shows that only five amount bits count, and the sign boundary of the greater-or-equal-zero compare can be tested at 0 and at the most negative value.

// File: rtl/cxa_pkg.sv
// Shared opcode encoding for the branch-steered unit array.
// Assumes a 4-bit opcode field at the bottom of every unit entry.
package cxa_pkg;

    typedef enum logic [3:0] {
        OP_PASS = 4'd0,
        OP_ADD  = 4'd1,
        OP_SUB  = 4'd2,
        OP_AND  = 4'd3,
        OP_OR   = 4'd4,
        OP_XOR  = 4'd5,
        OP_SLL  = 4'd6,
        OP_SRL  = 4'd7,
        OP_SRA  = 4'd8,
        OP_CEQ  = 4'd9,
        OP_CNE  = 4'd10,
        OP_CGEZ = 4'd11
    } op_e;

    // True for the opcodes that produce a branch flag
    function automatic logic is_cmp(input logic [3:0] op);
        return (op == OP_CEQ) || (op == OP_CNE) || (op == OP_CGEZ);
    endfunction

endpackage

// File: rtl/cxa_cfg.sv
// Configuration store: one register per unit entry and per output port entry.
// Assumes addresses 0..NU-1 are units and NU..NU+NOUT-1 are ports; others ignored.
module cxa_cfg #(
    parameter int NU   = 6,
    parameter int NOUT = 3,
    parameter int CW   = 28,
    parameter int PW   = 8,
    parameter int AW   = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [CW-1:0] wdata,
    output logic [CW-1:0] ucfg [NU],
    output logic [PW-1:0] pcfg [NOUT]
);

    for (genvar u = 0; u < NU; u++) begin : g_unit
        // Load one unit entry when its address is written
        always_ff @(posedge clk) begin
            if (!rst_n)
                ucfg[u] <= '0;
            else if (we && addr == AW'(u))
                ucfg[u] <= wdata;
        end
    end

    for (genvar p = 0; p < NOUT; p++) begin : g_port
        // Load one output port entry when its address is written
        always_ff @(posedge clk) begin
            if (!rst_n)
                pcfg[p] <= '0;
            else if (we && addr == AW'(NU + p))
                pcfg[p] <= wdata[PW-1:0];
        end
    end

    // R9: a unit write lands in the addressed entry
    assert_unit_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (we && int'(addr) < NU) |=> ucfg[$past(addr)] == $past(wdata));

endmodule

// File: rtl/cxa_fu.sv
// One functional unit: an ALU operation or a compare on two operands.
// Assumes the operands are already routed; compares drive data 0 and a flag.
module cxa_fu
    import cxa_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [3:0]   op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] res,
    output logic         flag
);

    localparam int SHW = $clog2(W);

    logic [SHW-1:0] sh;
    assign sh = b[SHW-1:0];

    // Compute the data result and the branch flag for the configured opcode
    always_comb begin
        res  = '0;
        flag = 1'b0;
        case (op)
            OP_PASS: res = a;
            OP_ADD:  res = a + b;
            OP_SUB:  res = a - b;
            OP_AND:  res = a & b;
            OP_OR:   res = a | b;
            OP_XOR:  res = a ^ b;
            OP_SLL:  res = a << sh;
            OP_SRL:  res = a >> sh;
            OP_SRA:  res = $signed(a) >>> sh;
            OP_CEQ:  flag = (a == b);
            OP_CNE:  flag = (a != b);
            OP_CGEZ: flag = !a[W-1];
            default: res = '0;
        endcase
    end

    // R3: only compare opcodes can raise the flag, and they leave data at zero
    always_comb begin
        if (flag)
            assert_flag_from_compare_R3: assert (is_cmp(op) && res == '0);
    end

endmodule

// File: rtl/cxa_opsel.sv
// Operand selector for one unit input: two candidate sources and a one-bit
// selector that forwards a compare unit's flag. Assumes ROW is the row of the
// unit it feeds; only units in earlier rows are visible.
module cxa_opsel #(
    parameter int W    = 32,
    parameter int NIN  = 4,
    parameter int NU   = 6,
    parameter int COLS = 2,
    parameter int ROW  = 0,
    parameter int SW   = 4,
    parameter int UW   = 3,
    parameter int OW   = 2 * SW + UW + 1
) (
    input  logic [NIN*W-1:0] pin,
    input  logic [W-1:0]     ures [NU],
    input  logic             ufl  [NU],
    input  logic [OW-1:0]    ocfg,
    output logic [W-1:0]     val
);

    logic [SW-1:0] src_nt;
    logic [SW-1:0] src_tk;
    logic          sel_en;
    logic [UW-1:0] sel_unit;
    logic          taken;

    assign src_nt   = ocfg[SW-1:0];
    assign src_tk   = ocfg[2*SW-1:SW];
    assign sel_en   = ocfg[2*SW];
    assign sel_unit = ocfg[2*SW+UW:2*SW+1];

    // Fetch the value named by a source code; illegal codes read zero
    function automatic logic [W-1:0] fetch(input logic [SW-1:0] code);
        int ci;
        int k;
        ci = int'(code);
        if (ci < NIN)
            return pin[ci*W +: W];
        k = ci - NIN;
        if (k < NU && (k / COLS) < ROW)
            return ures[k];
        return '0;
    endfunction

    // Selector: forward the flag of an earlier-row unit, else constant zero
    always_comb begin
        int ki;
        ki    = int'(sel_unit);
        taken = 1'b0;
        if (sel_en && ki < NU && (ki / COLS) < ROW)
            taken = ufl[ki];
    end

    // Data multiplexer steered by the selector outcome
    always_comb begin
        val = taken ? fetch(src_tk) : fetch(src_nt);
    end

endmodule

// File: rtl/cxa_array.sv
// Top of the branch-steered unit array. Rows of units evaluate combinationally
// from the primary inputs; a start pulse registers the port results and their
// valid bits and raises done one cycle later. Assumes configuration is steady
// while start is used.
module cxa_array
    import cxa_pkg::*;
#(
    parameter int W    = 32,
    parameter int ROWS = 3,
    parameter int COLS = 2,
    parameter int NIN  = 4,
    parameter int NOUT = 3,
    localparam int NU  = ROWS * COLS,
    localparam int SW  = $clog2(NIN + NU),
    localparam int UW  = $clog2(NU),
    localparam int OW  = 2 * SW + UW + 1,
    localparam int CW  = 4 + 2 * OW,
    localparam int PW  = 2 * UW + 2,
    localparam int AW  = $clog2(NU + NOUT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [AW-1:0]     cfg_addr,
    input  logic [CW-1:0]     cfg_wdata,
    input  logic [NIN*W-1:0]  in_data,
    input  logic              start,
    output logic              done,
    output logic [NOUT*W-1:0] out_data,
    output logic [NOUT-1:0]   out_valid
);

    logic [CW-1:0] ucfg [NU];
    logic [PW-1:0] pcfg [NOUT];
    logic [W-1:0]  ures [NU];
    logic          ufl  [NU];

    cxa_cfg #(.NU(NU), .NOUT(NOUT), .CW(CW), .PW(PW), .AW(AW)) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .addr  (cfg_addr),
        .wdata (cfg_wdata),
        .ucfg  (ucfg),
        .pcfg  (pcfg)
    );

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        for (genvar c = 0; c < COLS; c++) begin : g_col
            localparam int U = r * COLS + c;
            logic [W-1:0] opa;
            logic [W-1:0] opb;

            cxa_opsel #(.W(W), .NIN(NIN), .NU(NU), .COLS(COLS), .ROW(r),
                        .SW(SW), .UW(UW), .OW(OW)) u_sel_a (
                .pin  (in_data),
                .ures (ures),
                .ufl  (ufl),
                .ocfg (ucfg[U][4 +: OW]),
                .val  (opa)
            );

            cxa_opsel #(.W(W), .NIN(NIN), .NU(NU), .COLS(COLS), .ROW(r),
                        .SW(SW), .UW(UW), .OW(OW)) u_sel_b (
                .pin  (in_data),
                .ures (ures),
                .ufl  (ufl),
                .ocfg (ucfg[U][4+OW +: OW]),
                .val  (opb)
            );

            cxa_fu #(.W(W)) u_fu (
                .op   (ucfg[U][3:0]),
                .a    (opa),
                .b    (opb),
                .res  (ures[U]),
                .flag (ufl[U])
            );
        end
    end

    logic [W-1:0]    port_d [NOUT];
    logic [NOUT-1:0] port_v;

    for (genvar p = 0; p < NOUT; p++) begin : g_out
        logic [UW-1:0] dsel;
        logic          cen;
        logic [UW-1:0] csel;
        logic          pol;

        assign dsel = pcfg[p][UW-1:0];
        assign cen  = pcfg[p][UW];
        assign csel = pcfg[p][2*UW:UW+1];
        assign pol  = pcfg[p][2*UW+1];

        // Pick the reported unit and decide whether its path was taken
        always_comb begin
            logic cflag;
            port_d[p] = (int'(dsel) < NU) ? ures[dsel] : '0;
            cflag     = (int'(csel) < NU) ? ufl[csel] : 1'b0;
            port_v[p] = !cen || (cflag == pol);
        end

        // Capture this port's result on start
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                out_data[p*W +: W] <= '0;
                out_valid[p]       <= 1'b0;
            end else if (start) begin
                out_data[p*W +: W] <= port_d[p];
                out_valid[p]       <= port_v[p];
            end
        end

        // R7: an unconditional port is always reported valid
        assert_uncond_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (start && !pcfg[p][UW]) |=> out_valid[p]);
    end

    // Completion pulse one cycle after start
    always_ff @(posedge clk) begin
        if (!rst_n)
            done <= 1'b0;
        else
            done <= start;
    end

    // R8: done follows every start
    assert_done_after_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> done);

    // R8: no done without a start
    assert_no_spurious_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> !done);

    // R8: registered outputs hold between starts
    assert_outputs_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> ($stable(out_data) && $stable(out_valid)));

endmodule

// File: tb/sim_cxa_array.sv
module sim_cxa_array;

    localparam int W = 32;
    localparam int NIN = 4;
    localparam int NOUT = 3;
    localparam int CW = 28;
    localparam int AW = 4;
    localparam int NV = 5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_we = 1'b0;
    logic [AW-1:0]     cfg_addr = '0;
    logic [CW-1:0]     cfg_wdata = '0;
    logic [NIN*W-1:0]  in_data = '0;
    logic              start = 1'b0;
    logic              done;
    logic [NOUT*W-1:0] out_data;
    logic [NOUT-1:0]   out_valid;

    int n_run = 0;
    int n_fail = 0;
    bit ended = 1'b0;

    cxa_array u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .in_data   (in_data),
        .start     (start),
        .done      (done),
        .out_data  (out_data),
        .out_valid (out_valid)
    );

    always #4 clk = ~clk;

    // Table program: inputs and expected port results / valid bits
    localparam logic [31:0] TV_IN [NV][4] = '{
        '{32'd5,        32'd10,       32'd3,  32'd4},
        '{32'hFFFFFFFF, 32'd10,       32'd3,  32'd4},
        '{32'd2,        32'd1,        32'd6,  32'd6},
        '{32'h80000000, 32'h0000000F, 32'h0F, 32'h0F},
        '{32'd0,        32'hFFFFFFFF, 32'd1,  32'd2}
    };
    localparam logic [31:0] TV_OUT [NV][3] = '{
        '{32'd3,        32'hA0,       32'd7},
        '{32'd9,        32'hA0,       32'd7},
        '{32'hFFFFFFFD, 32'd4,        32'hFFFFFFFB},
        '{32'h11,       32'h0F,       32'd0},
        '{32'hFFFFFFFC, 32'hFFFFFFFC, 32'hFFFFFFFE}
    };
    localparam logic [2:0] TV_VAL [NV] = '{3'b001, 3'b101, 3'b011, 3'b111, 3'b001};

    function automatic logic [11:0] opnd(input int nt, input int tk, input int en, input int cu);
        return {3'(cu), 1'(en), 4'(tk), 4'(nt)};
    endfunction

    function automatic logic [CW-1:0] unit_w(input int op, input logic [11:0] a, input logic [11:0] b);
        return {b, a, 4'(op)};
    endfunction

    function automatic logic [CW-1:0] port_w(input int du, input int en, input int cu, input int pol);
        return CW'({1'(pol), 3'(cu), 1'(en), 3'(du)});
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic cfg_write(input int addr, input logic [CW-1:0] data);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_addr = AW'(addr);
        cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic run(input logic [31:0] i0, input logic [31:0] i1,
                       input logic [31:0] i2, input logic [31:0] i3);
        @(negedge clk);
        in_data = {i3, i2, i1, i0};
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    function automatic logic [31:0] port(input int p);
        return out_data[p*W +: W];
    endfunction

    task automatic load_program();
        cfg_write(0, unit_w(11, opnd(0,0,0,0), opnd(1,0,0,0)));
        cfg_write(1, unit_w(1,  opnd(1,0,0,0), opnd(2,0,0,0)));
        cfg_write(2, unit_w(2,  opnd(1,0,0,0), opnd(2,0,0,0)));
        cfg_write(3, unit_w(9,  opnd(2,0,0,0), opnd(3,0,0,0)));
        cfg_write(4, unit_w(5,  opnd(5,6,1,0), opnd(3,0,0,0)));
        cfg_write(5, unit_w(6,  opnd(1,0,0,0), opnd(3,0,1,3)));
        cfg_write(6, port_w(4, 0, 0, 0));
        cfg_write(7, port_w(5, 1, 3, 1));
        cfg_write(8, port_w(2, 1, 0, 0));
    endtask

    initial begin
        #(8 * 100000);
        if (!ended) begin
            ended = 1'b1;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] sweep_exp [13];
        logic        sweep_flag [13];
        sweep_exp = '{32'h80000010, 32'h80000034, 32'h7FFFFFEC, 32'h0, 32'h80000034,
                      32'h80000034, 32'h00000100, 32'h08000001, 32'hF8000001,
                      32'h0, 32'h0, 32'h0, 32'h0};
        sweep_flag = '{0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        check("R1 out_data", out_data[31:0] | out_data[63:32] | out_data[95:64], 32'h0);
        check("R1 out_valid", 32'(out_valid), 32'h0);
        check("R1 done", 32'(done), 32'h0);
        // R1: default configuration passes input 0 to every port
        run(32'h1234, 32'h1, 32'h2, 32'h3);
        check("R1 R8 done", 32'(done), 32'h1);
        for (int p = 0; p < NOUT; p++) check("R1 default port", port(p), 32'h1234);
        check("R1 default valid", 32'(out_valid), 32'h7);

        // Table walk over a branching program (R5, R7)
        load_program();
        for (int v = 0; v < NV; v++) begin
            run(TV_IN[v][0], TV_IN[v][1], TV_IN[v][2], TV_IN[v][3]);
            for (int p = 0; p < NOUT; p++) check("R5 table data", port(p), TV_OUT[v][p]);
            check("R7 table valid", 32'(out_valid), 32'(TV_VAL[v]));
        end

        // R9: writes beyond the last entry change nothing
        cfg_write(9, '1);
        cfg_write(15, '1);
        run(TV_IN[0][0], TV_IN[0][1], TV_IN[0][2], TV_IN[0][3]);
        for (int p = 0; p < NOUT; p++) check("R9 ignored write", port(p), TV_OUT[0][p]);
        check("R9 ignored write valid", 32'(out_valid), 32'(TV_VAL[0]));

        // R8: outputs hold and done stays low without start
        @(negedge clk);
        in_data = '1;
        repeat (2) @(negedge clk);
        check("R8 hold", port(0), TV_OUT[0][0]);
        check("R8 hold valid", 32'(out_valid), 32'(TV_VAL[0]));
        check("R8 done low", 32'(done), 32'h0);

        // R2 R3 R10: opcode sweep on unit 0, port 1 shows its flag
        do_reset();
        cfg_write(7, port_w(0, 1, 0, 1));
        for (int op = 0; op < 13; op++) begin
            cfg_write(0, unit_w(op, opnd(0,0,0,0), opnd(1,0,0,0)));
            run(32'h80000010, 32'h00000024, 32'h0, 32'h0);
            check("R2 R10 opcode data", port(0), sweep_exp[op]);
            check("R3 opcode flag", 32'(out_valid), {29'h0, 1'b1, sweep_flag[op], 1'b1});
        end

        // R4: illegal references read zero, legal ones pass through
        do_reset();
        cfg_write(0, unit_w(0, opnd(4,0,0,0), opnd(0,0,0,0)));
        cfg_write(1, unit_w(0, opnd(1,0,0,0), opnd(0,0,0,0)));
        cfg_write(2, unit_w(0, opnd(7,0,0,0), opnd(0,0,0,0)));
        cfg_write(3, unit_w(0, opnd(5,0,0,0), opnd(0,0,0,0)));
        cfg_write(4, unit_w(0, opnd(15,0,0,0), opnd(0,0,0,0)));
        cfg_write(6, port_w(2, 0, 0, 0));
        cfg_write(7, port_w(0, 0, 0, 0));
        cfg_write(8, port_w(4, 0, 0, 0));
        run(32'hAAAA0001, 32'h5555000B, 32'h3, 32'h4);
        check("R4 same-row source", port(0), 32'h0);
        check("R4 self source", port(1), 32'h0);
        check("R4 out-of-range source", port(2), 32'h0);
        cfg_write(6, port_w(3, 0, 0, 0));
        run(32'hAAAA0001, 32'h5555000B, 32'h3, 32'h4);
        check("R4 earlier-row source", port(0), 32'h5555000B);

        // R5 R6: selector behaviour
        do_reset();
        cfg_write(0, unit_w(1, opnd(0,0,0,0), opnd(1,0,0,0)));
        cfg_write(1, unit_w(9, opnd(0,0,0,0), opnd(0,0,0,0)));
        cfg_write(2, unit_w(0, opnd(2,3,1,0), opnd(0,0,0,0)));
        cfg_write(3, unit_w(0, opnd(2,3,1,1), opnd(0,0,0,0)));
        cfg_write(4, unit_w(0, opnd(2,3,0,1), opnd(0,0,0,0)));
        cfg_write(6, port_w(2, 0, 0, 0));
        cfg_write(7, port_w(3, 0, 0, 0));
        cfg_write(8, port_w(4, 0, 0, 0));
        run(32'h7, 32'h9, 32'h22, 32'h33);
        check("R6 non-branch selector", port(0), 32'h22);
        check("R5 taken selector", port(1), 32'h33);
        check("R5 disabled selector", port(2), 32'h22);
        cfg_write(2, unit_w(9, opnd(0,0,0,0), opnd(0,0,0,0)));
        cfg_write(3, unit_w(0, opnd(2,3,1,2), opnd(0,0,0,0)));
        cfg_write(4, unit_w(0, opnd(2,3,1,7), opnd(0,0,0,0)));
        run(32'h7, 32'h9, 32'h22, 32'h33);
        check("R6 same-row selector", port(1), 32'h22);
        check("R6 missing-unit selector", port(2), 32'h22);

        // R7: out-of-range data unit and missing condition unit
        cfg_write(6, port_w(7, 1, 7, 0));
        cfg_write(7, port_w(1, 1, 6, 1));
        run(32'h7, 32'h9, 32'h22, 32'h33);
        check("R7 missing data unit", port(0), 32'h0);
        check("R7 missing cond valid", 32'(out_valid), 32'h5);

        if (!ended) begin
            ended = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule